// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block is a tagless table of per-branch direction predictors that the fetch stage reads with its current program counter. Each entry is either a single last-outcome bit or a two-bit saturating counter, selected at build time. The read side returns a taken/not-taken guess for the fetch address with no clock delay.

When a branch resolves, the pipeline presents its address, its real direction and the guess made for it at fetch time. The block flags a mispredict in that same cycle so that flush logic can discard wrong-path work. At the next clock edge it trains the entry that address maps to.

Branches whose addresses share the index bits share one entry. This can reduce accuracy but never affects correctness.

Top module: `branch_history_table`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry is cleared to its not-taken value (0 in one-bit mode, strongly not-taken 0 in two-bit mode). After reset, `pred_taken` is 0 for every address.
- R2: The entry index is `pc[IDX_W+1:2]`. Address bits [1:0] and bits above the index take no part. Two addresses that agree in the index bits read and train the same entry.
- R3: In one-bit mode (`CTR_W`=1), a valid update makes the stored bit equal to the resolved direction, which inverts it on a miss. `pred_taken` is the stored bit.
- R4: In two-bit mode (`CTR_W`=2), the counter codes 0 as strongly not-taken, 1 as weakly not-taken, 2 as weakly taken and 3 as strongly taken. `pred_taken` is bit 1 of the counter. A taken outcome adds one to the counter and a not-taken outcome subtracts one, so a strong state must miss twice before its guess flips.
- R5: In two-bit mode, the counter saturates at 3 and at 0. Extra taken outcomes at 3 leave it at 3.
- R6: `mispredict` is 1 in the same cycle exactly when `upd_valid` is 1 and `upd_taken` differs from `upd_pred`.
- R7: When a read and an update hit the same entry in one cycle, `pred_taken` shows the value before the update. The new value appears after the clock edge.
- R8: When `upd_valid` is 0, no entry changes.
- R9: Consider a loop branch taken 9 times and then not taken, repeated 10 times from reset. Two-bit mode flags 12 mispredicts and one-bit mode flags 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_pred | input | 1 | Direction that was predicted at fetch |
| mispredict | output | 1 | Resolved direction differs from the prediction |

## Verification
The hardest case to reach from the ports is a counter sitting at a saturation limit and then getting a further outcome in the same direction. Such a counter looks identical to one a step away, because `pred_taken` exposes only the top bit. The bench drives one entry with five taken outcomes and then two not-taken ones. A counter that wraps instead of saturating shows the wrong guess after the first not-taken.

The bench also replays the nine-taken, one-not-taken loop ten times against a one-bit and a two-bit instance side by side, and compares their mispredict totals. Aliasing is reached by training one address and then reading another that differs only above the index bits or in bits [1:0].

// File: rtl/bht_pkg.sv
// Shared constants for the branch direction predictor table.
// Assumes counters are one or two bits wide.
package bht_pkg;
    localparam int unsigned BHT_PC_LSB = 2;  // word-aligned fetch addresses
endpackage

// File: rtl/bht_index.sv
// Maps a program counter to a table index using the bits just above the
// word offset. Assumes PC_W > IDX_W + 2, so upper bits exist and are dropped.
module bht_index #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    import bht_pkg::*;
    localparam int unsigned HI = BHT_PC_LSB + IDX_W;

    logic unused_bits;

    // slice out the index field, ignore everything else
    always_comb begin
        idx         = pc[HI-1:BHT_PC_LSB];
        unused_bits = ^{pc[PC_W-1:HI], pc[BHT_PC_LSB-1:0]};
    end
endmodule

// File: rtl/bht_next_state.sv
// Computes the trained value of one entry from its current value and the
// resolved direction. CTR_W selects last-outcome (1) or saturating
// counter (2) behaviour.
module bht_next_state #(
    parameter int unsigned CTR_W = 2
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             taken,
    output logic [CTR_W-1:0] nxt
);
    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CMIN = '0;
    localparam logic [CTR_W-1:0] ONE  = CTR_W'(1);

    generate
        if (CTR_W == 1) begin : g_last
            // last-outcome bit: store the direction itself
            always_comb nxt = taken;
        end else begin : g_sat
            // saturating up/down counter
            always_comb begin
                if (taken)
                    nxt = (cur == CMAX) ? cur : cur + ONE;
                else
                    nxt = (cur == CMIN) ? cur : cur - ONE;
            end
        end
    endgenerate
endmodule

// File: rtl/bht_table.sv
// Storage for all predictor entries: one asynchronous read port and one
// clocked training port. A read returns the value held before any write
// at the same edge. Synchronous active-low reset clears every entry.
module bht_table #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

    logic [ENTRIES-1:0][CTR_W-1:0] mem;
    logic [CTR_W-1:0] wr_cur;
    logic [CTR_W-1:0] wr_nxt;

    // fetch-side and training-side lookups
    always_comb begin
        rd_state = mem[rd_idx];
        wr_cur   = mem[wr_idx];
    end

    bht_next_state #(.CTR_W(CTR_W)) nxt_i (
        .cur   (wr_cur),
        .taken (wr_taken),
        .nxt   (wr_nxt)
    );

    // clear on reset, otherwise train one entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem <= '0;
        else if (wr_en)
            mem[wr_idx] <= wr_nxt;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (mem == '0));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(mem));

    // R4
    taken_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> (mem[$past(wr_idx)] >= $past(wr_cur)));

    // R4
    nottaken_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> (mem[$past(wr_idx)] <= $past(wr_cur)));

    // R5
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur == CMAX) |=> (mem[$past(wr_idx)] == CMAX));
endmodule

// File: rtl/branch_history_table.sv
// Tagless branch direction predictor. The fetch address is indexed and
// predicted without a clock delay. Resolved branches train their entry
// at the next edge and raise mispredict combinationally.
// Assumes the caller returns the fetch-time guess on upd_pred.
module branch_history_table #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CTR_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_pred,
    output logic            mispredict
);
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [CTR_W-1:0] rd_state;

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) rd_ix_i (.pc(fetch_pc), .idx(rd_idx));
    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) wr_ix_i (.pc(upd_pc),   .idx(wr_idx));

    bht_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) tbl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_state (rd_state),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    // direction is the top bit of the entry; miss when outcome disagrees
    always_comb begin
        pred_taken = rd_state[CTR_W-1];
        mispredict = upd_valid && (upd_taken != upd_pred);
    end

    // R6
    miss_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> upd_valid);
endmodule

// File: tb/branch_history_table_tb.sv
// Directed bench: one two-bit instance (dut_i) and one one-bit instance
// driven with the same stimulus.
module branch_history_table_tb_top;
    localparam int CLK_P = 10;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam logic [PC_W-1:0] SPAN = 32'(4 << IDX_W);

    logic clk = 0;
    logic rst_n = 0;
    logic [PC_W-1:0] fetch_pc = '0, upd_pc = '0;
    logic upd_valid = 0, upd_taken = 0, upd_pred2 = 0, upd_pred1 = 0;
    logic pred2, pred1, mis2, mis1;
    logic s_mis2, s_mis1;
    int n_checks = 0, n_errs = 0;

    always #(CLK_P/2) clk = ~clk;

    branch_history_table #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_pred(upd_pred2), .mispredict(mis2));

    branch_history_table #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(1)) dut_1b_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_pred(upd_pred1), .mispredict(mis1));

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one resolved branch: guess read at fetch, then trained at the edge
    task automatic apply(input logic [PC_W-1:0] pc, input logic tk, input logic vld);
        @(negedge clk);
        fetch_pc  = pc;
        upd_pc    = pc;
        upd_valid = 0;
        #1;
        upd_pred2 = pred2;
        upd_pred1 = pred1;
        upd_taken = tk;
        upd_valid = vld;
        #1;
        s_mis2 = mis2;
        s_mis1 = mis1;
        @(posedge clk);
        #1 upd_valid = 0;
    endtask

    task automatic peek(input logic [PC_W-1:0] pc);
        @(negedge clk);
        upd_valid = 0;
        fetch_pc  = pc;
        #1;
    endtask

    task automatic t_reset();
        peek(32'h10); check(pred2, 0, "R1 2b"); check(pred1, 0, "R1 1b");
        peek(32'hFC); check(pred2, 0, "R1 2b top"); check(pred1, 0, "R1 1b top");
    endtask

    task automatic t_alias();
        apply(32'h20, 1, 1); apply(32'h20, 1, 1);
        peek(32'h20 + SPAN); check(pred1, 1, "R2 upper alias 1b"); check(pred2, 1, "R2 upper alias 2b");
        peek(32'h23); check(pred1, 1, "R2 low bits ignored");
        peek(32'h24); check(pred1, 0, "R2 neighbour untouched");
    endtask

    task automatic t_one_bit();
        apply(32'h30, 1, 1); peek(32'h30); check(pred1, 1, "R3 taken");
        apply(32'h30, 0, 1); peek(32'h30); check(pred1, 0, "R3 invert");
        apply(32'h30, 1, 1); apply(32'h30, 1, 1); peek(32'h30); check(pred1, 1, "R3 stay");
    endtask

    task automatic t_two_bit();
        apply(32'h40, 1, 1); peek(32'h40); check(pred2, 0, "R4 weak nt");
        apply(32'h40, 1, 1); peek(32'h40); check(pred2, 1, "R4 weak t");
        apply(32'h40, 1, 1); apply(32'h40, 0, 1); peek(32'h40); check(pred2, 1, "R4 one miss holds");
        apply(32'h40, 0, 1); peek(32'h40); check(pred2, 0, "R4 two misses flip");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 5; i++) apply(32'h50, 1, 1);
        peek(32'h50); check(pred2, 1, "R5 top");
        apply(32'h50, 0, 1); peek(32'h50); check(pred2, 1, "R5 sat then miss");
        apply(32'h50, 0, 1); peek(32'h50); check(pred2, 0, "R5 second miss");
        for (int i = 0; i < 4; i++) apply(32'h50, 0, 1);
        apply(32'h50, 1, 1); peek(32'h50); check(pred2, 0, "R5 bottom sat");
    endtask

    task automatic t_mispredict();
        @(negedge clk);
        upd_pc = 32'h60; upd_taken = 1; upd_pred2 = 0; upd_valid = 1;
        #1 check(mis2, 1, "R6 miss");
        upd_pred2 = 1; #1 check(mis2, 0, "R6 hit");
        upd_pred2 = 0; upd_valid = 0; #1 check(mis2, 0, "R6 no valid");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fetch_pc = 32'h64; upd_pc = 32'h64; upd_taken = 1; upd_pred1 = 0; upd_valid = 1;
        #1 check(pred1, 0, "R7 pre-update value");
        @(posedge clk); #1 upd_valid = 0;
        peek(32'h64); check(pred1, 1, "R7 after edge");
    endtask

    task automatic t_ignore();
        for (int i = 0; i < 3; i++) apply(32'h68, 1, 0);
        peek(32'h68); check(pred1, 0, "R8 1b"); check(pred2, 0, "R8 2b");
    endtask

    task automatic t_loop();
        int m2 = 0, m1 = 0;
        for (int v = 0; v < 10; v++)
            for (int it = 0; it < 10; it++) begin
                apply(32'h70, (it < 9), 1);
                m2 += int'(s_mis2);
                m1 += int'(s_mis1);
            end
        check(m2, 12, "R9 2b mispredicts");
        check(m1, 20, "R9 1b mispredicts");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_alias();
        t_one_bit();
        t_two_bit();
        t_saturate();
        t_mispredict();
        t_same_cycle();
        t_ignore();
        t_loop();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule